// File: doc/BRIEF.md
# Alarm and Interrupt Unit for a Clock/Calendar

This unit sits next to a BCD clock counter chain and watches it. Each cycle it receives the seven counter bytes: hundredths, seconds, minutes, hours, year/date, weekday/month and timer. It also receives the seven alarm bytes that shadow those counters, the control byte, the alarm control byte and one strobe per time unit. It decides when an alarm has occurred and holds the result in two sticky flags, one for the alarm and one for the timer. These flags drive an active-low pull-down enable for an open-drain interrupt pin. It also tells the counter chain when to advance the timer byte. The bus interface and the counters themselves are outside this block.

When the control byte's alarm-enable bit is clear, the alarm bytes are ordinary storage, and the unit never reports a match. In clock mode it then uses the interrupt pin as a 1 Hz square wave with 50 % duty, derived from the hundredths strobe. When the bit is set, the alarm control byte selects:
- the alarm kind: daily, weekday or dated;
- a separate timer alarm;
- the timer resolution;
- the two interrupt enables.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset both flags read 0, the interrupt pull-down is released, and the calibration wave starts low.
- R2: With control bit 2 clear, no matching condition sets the alarm flag. In clock mode (control bits 5:4 not equal to 2'b10), `int_drive_low_o` equals the calibration wave. In event mode (bits 5:4 = 2'b10) it is released.
- R3: `timer_inc_o` selects one strobe. With control bit 2 clear, it follows the day strobe (tick bit 4). With bit 2 set, alarm control bits 2:0 select the strobe: 1 hundredths (tick bit 0), 2 seconds (bit 1), 3 minutes (bit 2), 4 hours (bit 3), 5 days (bit 4). Any other code gives no increment.
- R4: A timer increment while the timer byte (byte 7) is 8'h99 sets the timer flag (flag bit 0) on the next clock.
- R5: Daily alarm (alarm control bits 5:4 = 2'b01): bytes 1–4 all equal their alarm bytes on a hundredths strobe. This sets the alarm flag (flag bit 1).
- R6: Dated alarm (bits 5:4 = 2'b11): this adds a compare of the date field (byte 5 bits 5:0) and the month field (byte 6 bits 4:0). The year (byte 5 bits 7:6) and the weekday (byte 6 bits 7:5) are ignored.
- R7: Weekday alarm (bits 5:4 = 2'b10): bytes 1–4 must match. In addition, alarm byte 6 bit N must be set, where N is the counter's weekday (byte 6 bits 7:5).
- R8: Timer alarm (alarm control bit 6): the timer byte equals alarm byte 7 on a hundredths strobe. This sets the alarm flag.
- R9: A match is acted on only at its first hundredths strobe. A match that lasts over several strobes sets the flag once. After the flag is cleared, it stays clear while the match persists.
- R10: A write strobe ANDs the flags with `flag_wdata_i`: bit 1 is the alarm flag and bit 0 the timer flag. A set event in the same cycle wins over the clear. Otherwise the flags hold.
- R11: With control bit 2 set, the pull-down is on while the alarm flag is set with alarm control bit 7 set, or while the timer flag is set with alarm control bit 3 set.
- R12: The calibration wave toggles on every HALF_TICKS-th hundredths strobe (50 by default) and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 5 | Unit strobes: bit 0 hundredths, bit 1 seconds, bit 2 minutes, bit 3 hours, bit 4 days |
| ctrl_i | input | 8 | Control byte: bit 2 alarm enable, bits 5:4 counting mode |
| alarm_ctrl_i | input | 8 | Alarm control byte: 2:0 timer resolution, 3 timer interrupt enable, 5:4 alarm kind, 6 timer alarm enable, 7 alarm interrupt enable |
| cnt_bytes_i | input | 56 | Counter bytes 1..7, byte k at bits 8(k-1)+7:8(k-1) |
| alm_bytes_i | input | 56 | Alarm bytes, same layout as the counter bytes |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 2 | Flag write data: bit 1 alarm, bit 0 timer |
| flags_o | output | 2 | Sticky flags: bit 1 alarm, bit 0 timer |
| timer_inc_o | output | 1 | Advance request for the timer byte |
| int_drive_low_o | output | 1 | Pull-down enable for the interrupt pin |

## Verification
The hardest situation to reach is a clear that races a set. A match must fall away for one hundredths strobe and then return on the same cycle that software writes a zero to the flag. The stimulus first breaks the match by changing the hundredths byte, which rearms the edge detection. It then restores the byte, which raises the strobe and the write strobe together. A second hard case is a match that persists after its flag was cleared. The stimulus holds every counter and alarm byte fixed across several strobes while it clears the flag, so that the edge qualification alone keeps the flag down.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'b00,
        KIND_DAILY   = 2'b01,
        KIND_WEEKDAY = 2'b10,
        KIND_DATED   = 2'b11
    } alarm_kind_e;

    localparam int CTRL_ALM_EN   = 2;
    localparam int ACTL_TMR_IE   = 3;
    localparam int ACTL_TMR_ALM  = 6;
    localparam int ACTL_ALM_IE   = 7;
    localparam logic [1:0] MODE_EVENT = 2'b10;
    localparam logic [7:0] TIMER_TOP  = 8'h99;

    typedef struct packed {
        logic alarm_flag;
        logic timer_flag;
        logic tod_prev;
        logic tmr_prev;
    } flag_state_t;

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_irq_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 7
) (
    input  logic [N_BYTES*BYTE_W-1:0] cnt_i,
    input  logic [N_BYTES*BYTE_W-1:0] alm_i,
    input  alarm_kind_e               kind_i,
    input  logic                      tmr_en_i,
    output logic                      tod_match_o,
    output logic                      tmr_match_o
);
    localparam int N_TIME  = 4;
    localparam int IDX_YD  = 4;
    localparam int IDX_WM  = 5;
    localparam int IDX_TMR = 6;

    logic [N_TIME-1:0]  time_eq;
    logic               date_eq;
    logic               month_eq;
    logic [2:0]         wday;
    logic [BYTE_W-1:0]  wday_mask;
    logic               wday_ok;
    logic               time_all;

    for (genvar g = 0; g < N_TIME; g++) begin : g_time
        assign time_eq[g] = cnt_i[g*BYTE_W +: BYTE_W] == alm_i[g*BYTE_W +: BYTE_W];
    end

    assign time_all  = &time_eq;
    assign date_eq   = cnt_i[IDX_YD*BYTE_W +: 6] == alm_i[IDX_YD*BYTE_W +: 6];
    assign month_eq  = cnt_i[IDX_WM*BYTE_W +: 5] == alm_i[IDX_WM*BYTE_W +: 5];
    assign wday      = cnt_i[IDX_WM*BYTE_W + 5 +: 3];
    assign wday_mask = alm_i[IDX_WM*BYTE_W +: BYTE_W];
    assign wday_ok   = (wday != 3'd7) && wday_mask[wday];

    always_comb begin
        unique case (kind_i)
            KIND_DAILY:   tod_match_o = time_all;
            KIND_WEEKDAY: tod_match_o = time_all && wday_ok;
            KIND_DATED:   tod_match_o = time_all && date_eq && month_eq;
            default:      tod_match_o = 1'b0;
        endcase
    end

    assign tmr_match_o = tmr_en_i &&
        (cnt_i[IDX_TMR*BYTE_W +: BYTE_W] == alm_i[IDX_TMR*BYTE_W +: BYTE_W]);

endmodule

// File: rtl/timer_tick_sel.sv
module timer_tick_sel #(
    parameter int N_TICKS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TICKS-1:0] tick_i,
    input  logic               alarms_on_i,
    input  logic [2:0]         res_i,
    output logic               inc_o
);
    always_comb begin
        inc_o = 1'b0;
        if (!alarms_on_i) begin
            inc_o = tick_i[N_TICKS-1];
        end else if (res_i != 3'd0 && int'(res_i) <= N_TICKS) begin
            inc_o = tick_i[res_i - 3'd1];
        end
    end

    p_inc_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o |-> (tick_i != '0));

endmodule

// File: rtl/cal_wave.sv
module cal_wave #(
    parameter int HALF_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic wave_o
);
    localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          sq_d, sq_q;

    always_comb begin
        cnt_d = cnt_q;
        sq_d  = sq_q;
        if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                sq_d  = ~sq_q;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sq_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            sq_q  <= sq_d;
        end
    end

    assign wave_o = sq_q;

    p_wave_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(wave_o));

endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_irq_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int N_BYTES    = 7,
    parameter int N_TICKS    = 5,
    parameter int HALF_TICKS = 50
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_TICKS-1:0]        tick_i,
    input  logic [BYTE_W-1:0]         ctrl_i,
    input  logic [BYTE_W-1:0]         alarm_ctrl_i,
    input  logic [N_BYTES*BYTE_W-1:0] cnt_bytes_i,
    input  logic [N_BYTES*BYTE_W-1:0] alm_bytes_i,
    input  logic                      flag_wr_i,
    input  logic [1:0]                flag_wdata_i,
    output logic [1:0]                flags_o,
    output logic                      timer_inc_o,
    output logic                      int_drive_low_o
);
    localparam int TMR_LSB = (N_BYTES - 1) * BYTE_W;

    flag_state_t st_d, st_q;
    alarm_kind_e kind;
    logic        alarms_on, clock_mode, hund;
    logic        tod_match, tmr_match, wave;
    logic [BYTE_W-1:0] timer_val;

    assign alarms_on  = ctrl_i[CTRL_ALM_EN];
    assign clock_mode = ctrl_i[5:4] != MODE_EVENT;
    assign hund       = tick_i[0];
    assign kind       = alarms_on ? alarm_kind_e'(alarm_ctrl_i[5:4]) : KIND_NONE;
    assign timer_val  = cnt_bytes_i[TMR_LSB +: BYTE_W];

    alarm_match #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_match (
        .cnt_i       (cnt_bytes_i),
        .alm_i       (alm_bytes_i),
        .kind_i      (kind),
        .tmr_en_i    (alarms_on && alarm_ctrl_i[ACTL_TMR_ALM]),
        .tod_match_o (tod_match),
        .tmr_match_o (tmr_match)
    );

    timer_tick_sel #(.N_TICKS(N_TICKS)) u_tsel (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .alarms_on_i (alarms_on),
        .res_i       (alarm_ctrl_i[2:0]),
        .inc_o       (timer_inc_o)
    );

    cal_wave #(.HALF_TICKS(HALF_TICKS)) u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (hund),
        .wave_o (wave)
    );

    always_comb begin
        st_d = st_q;
        if (flag_wr_i) begin
            if (!flag_wdata_i[1]) st_d.alarm_flag = 1'b0;
            if (!flag_wdata_i[0]) st_d.timer_flag = 1'b0;
        end
        if (hund) begin
            st_d.tod_prev = tod_match;
            st_d.tmr_prev = tmr_match;
            if ((tod_match && !st_q.tod_prev) || (tmr_match && !st_q.tmr_prev))
                st_d.alarm_flag = 1'b1;
        end
        if (timer_inc_o && timer_val == TIMER_TOP)
            st_d.timer_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = {st_q.alarm_flag, st_q.timer_flag};

    always_comb begin
        if (alarms_on)
            int_drive_low_o = (st_q.alarm_flag && alarm_ctrl_i[ACTL_ALM_IE]) ||
                              (st_q.timer_flag && alarm_ctrl_i[ACTL_TMR_IE]);
        else
            int_drive_low_o = clock_mode && wave;
    end

    p_overflow_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_inc_o && timer_val == TIMER_TOP) |=> flags_o[0]);

    p_alarm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[1] && !(flag_wr_i && !flag_wdata_i[1])) |=> flags_o[1]);

    p_timer_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[0] && !(flag_wr_i && !flag_wdata_i[0])) |=> flags_o[0]);

    p_alarm_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[1]) |-> $past(hund));

    p_no_alarm_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarms_on && !flags_o[1]) |=> !flags_o[1]);

    p_irq_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (alarms_on && flags_o[1] && alarm_ctrl_i[ACTL_ALM_IE]) |-> int_drive_low_o);

endmodule

// File: tb/alarm_irq_unit_test.sv
module alarm_irq_unit_test;

    typedef struct {
        logic [1:0] flags;
        logic       drv;
        logic       inc;
        int         req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  tick = '0;
    logic [7:0]  ctrl = '0;
    logic [7:0]  actl = '0;
    logic [55:0] cnt = '0;
    logic [55:0] alm = '0;
    logic        wr = 1'b0;
    logic [1:0]  wd = '0;
    logic [1:0]  flags;
    logic        tinc, drv;

    int   n_run = 0, n_fail = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    alarm_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ctrl_i(ctrl),
        .alarm_ctrl_i(actl), .cnt_bytes_i(cnt), .alm_bytes_i(alm),
        .flag_wr_i(wr), .flag_wdata_i(wd), .flags_o(flags),
        .timer_inc_o(tinc), .int_drive_low_o(drv)
    );

    // monitor: compares shortly after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (flags !== e.flags || drv !== e.drv || tinc !== e.inc) begin
                n_fail++;
                $display("FAIL R%0d: flags=%b drv=%b inc=%b expected flags=%b drv=%b inc=%b",
                         e.req, flags, drv, tinc, e.flags, e.drv, e.inc);
            end
        end
    end

    task automatic step(input logic [4:0] tk, input logic w, input logic [1:0] wdat,
                        input logic [1:0] ef, input logic ed, input logic ei, input int rq);
        exp_t e;
        @(negedge clk);
        tick = tk; wr = w; wd = wdat;
        e.flags = ef; e.drv = ed; e.inc = ei; e.req = rq;
        q.push_back(e);
        @(posedge clk);
        #3;
    endtask

    task automatic setc(input int k, input logic [7:0] v); cnt[8*(k-1) +: 8] = v; endtask
    task automatic seta(input int k, input logic [7:0] v); alm[8*(k-1) +: 8] = v; endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung, expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_run++; // R1 reset state
        if (flags !== 2'b00 || drv !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: flags=%b drv=%b expected flags=00 drv=0", flags, drv);
        end

        // R12 / R2: calibration wave with alarms disabled, clock mode
        for (int i = 0; i < 50; i++) step(5'b00001, 0, 2'b11, 2'b00, (i == 49), 1'b0, 12);
        step(5'b10000, 0, 2'b11, 2'b00, 1'b1, 1'b1, 3);       // R3 day strobe when alarms off
        ctrl = 8'h20;
        step(5'b00000, 0, 2'b11, 2'b00, 1'b0, 1'b0, 2);       // R2 event mode releases pin
        actl = 8'h30;
        step(5'b00001, 0, 2'b11, 2'b00, 1'b0, 1'b0, 2);       // R2 match ignored when disabled

        // R6 dated alarm, all bytes zero match
        ctrl = 8'h04; actl = 8'h31;
        step(5'b00001, 0, 2'b11, 2'b10, 1'b0, 1'b1, 6);
        // R9 held match: clear then more strobes keep it clear
        step(5'b00001, 1, 2'b00, 2'b00, 1'b0, 1'b1, 9);
        step(5'b00001, 0, 2'b11, 2'b00, 1'b0, 1'b1, 9);
        // R10 set wins over simultaneous clear
        setc(1, 8'h01);
        step(5'b00001, 0, 2'b11, 2'b00, 1'b0, 1'b1, 10);
        setc(1, 8'h00);
        step(5'b00001, 1, 2'b00, 2'b10, 1'b0, 1'b1, 10);
        // R11 alarm interrupt enable
        actl = 8'hB1;
        step(5'b00000, 0, 2'b11, 2'b10, 1'b1, 1'b0, 11);
        step(5'b00000, 1, 2'b01, 2'b00, 1'b0, 1'b0, 10);

        // R6 year and weekday ignored, date compared
        actl = 8'h31; setc(1, 8'h01);
        step(5'b00001, 0, 2'b11, 2'b00, 1'b0, 1'b1, 6);
        setc(1, 8'h00); setc(5, 8'hC0); setc(6, 8'hE0);
        step(5'b00001, 0, 2'b11, 2'b10, 1'b0, 1'b1, 6);
        step(5'b00000, 1, 2'b00, 2'b00, 1'b0, 1'b0, 10);
        setc(5, 8'hC1);
        step(5'b00001, 0, 2'b11, 2'b00, 1'b0, 1'b1, 6);

        // R5 daily ignores date
        actl = 8'h11;
        step(5'b00001, 0, 2'b11, 2'b10, 1'b0, 1'b1, 5);
        step(5'b00000, 1, 2'b00, 2'b00, 1'b0, 1'b0, 10);
        setc(3, 8'h05);
        step(5'b00001, 0, 2'b11, 2'b00, 1'b0, 1'b1, 5);

        // R7 weekday bitmap (weekday 3 in byte 6 bits 7:5)
        setc(3, 8'h00); setc(6, 8'h60); seta(6, 8'h08); actl = 8'h21;
        step(5'b00001, 0, 2'b11, 2'b10, 1'b0, 1'b1, 7);
        step(5'b00000, 1, 2'b00, 2'b00, 1'b0, 1'b0, 10);
        seta(6, 8'h10);
        step(5'b00001, 0, 2'b11, 2'b00, 1'b0, 1'b1, 7);
        seta(6, 8'h08);
        step(5'b00001, 0, 2'b11, 2'b10, 1'b0, 1'b1, 7);
        step(5'b00000, 1, 2'b00, 2'b00, 1'b0, 1'b0, 10);

        // R8 timer alarm
        actl = 8'h41; setc(7, 8'h25); seta(7, 8'h25);
        step(5'b00001, 0, 2'b11, 2'b10, 1'b0, 1'b1, 8);
        step(5'b00000, 1, 2'b00, 2'b00, 1'b0, 1'b0, 10);

        // R4 overflow at seconds resolution
        actl = 8'h02; setc(7, 8'h99);
        step(5'b00001, 0, 2'b11, 2'b00, 1'b0, 1'b0, 3);
        step(5'b00010, 0, 2'b11, 2'b01, 1'b0, 1'b1, 4);
        actl = 8'h0A;
        step(5'b00000, 0, 2'b11, 2'b01, 1'b1, 1'b0, 11);
        step(5'b00000, 1, 2'b10, 2'b00, 1'b0, 1'b0, 10);

        // R3 remaining resolutions
        setc(7, 8'h00);
        actl = 8'h03; step(5'b00100, 0, 2'b11, 2'b00, 1'b0, 1'b1, 3);
        actl = 8'h04; step(5'b01000, 0, 2'b11, 2'b00, 1'b0, 1'b1, 3);
        actl = 8'h05; step(5'b10000, 0, 2'b11, 2'b00, 1'b0, 1'b1, 3);
        actl = 8'h05; step(5'b01111, 0, 2'b11, 2'b00, 1'b0, 1'b0, 3);
        actl = 8'h00; step(5'b11111, 0, 2'b11, 2'b00, 1'b0, 1'b0, 3);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule